// File: doc/BRIEF.md
# Receive FIFO with Error Tracking

This block is the receive-side store of a serial port. Each accepted character is kept with three tags beside its data byte: parity error, framing error and break. The host sees the oldest character and its tags on the read-head outputs. A data-read strobe removes that character. A status-read strobe acknowledges pending line-status events.

A counter of tagged entries drives a summary flag. The flag stays high while any bad character is anywhere in the store, and it drops by itself when the last one is read out. A line-status interrupt can be raised at one of two moments, chosen by a timing-mode input. In deferred mode it is raised only when a bad character reaches the read head. In immediate mode it is also raised as soon as the bad character is accepted. In that mode it fires a second time when the character later reaches the head, provided it was acknowledged in the meantime. A write to a full store is dropped and recorded in a sticky overrun flag.

Top module: `rx_err_fifo`

## Requirements
- R1: Characters and their tags leave in the order they were accepted. The head outputs show the oldest stored entry without delay. A data read that is accepted removes that entry.
- R2: After reset the store is empty. `level` is 0, and `err_any`, `overrun` and `lsr_irq` are 0.
- R3: A write while the store is full and no read is accepted is discarded. It leaves `level` at DEPTH and the head unchanged, and it sets `overrun` at the next edge. `overrun` is cleared by a status read.
- R4: `err_any` is 1 whenever at least one stored entry has any of its tags set. The tag positions are pe at bit 0, fe at bit 1 and brk at bit 2.
- R5: `err_any` returns to 0 by itself in the cycle after the last tagged entry is read out.
- R6: `lsr_irq` is the pending line-status event gated by `irq_en`. While `irq_en` is 0 the output is 0, and the pending event is kept.
- R7: In deferred mode (`imm_mode`=0), a tagged entry makes the event pending one edge after the edge that placed it at the head. Accepting a tagged entry behind other entries raises nothing.
- R8: In immediate mode (`imm_mode`=1), accepting a tagged entry makes the event pending at that same edge.
- R9: A status read clears the pending event, unless a new event arrives in the same cycle.
- R10: In immediate mode, an acknowledged tagged entry raises the event again one edge after it reaches the head.
- R11: A data read while the store is empty is ignored. The store stays empty and later writes are stored normally.
- R12: A write and a read together while full are both accepted. `level` stays at DEPTH and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for an incoming character |
| wr_data | input | DATA_W | Incoming data byte |
| wr_pe | input | 1 | Parity-error tag of the incoming character |
| wr_fe | input | 1 | Framing-error tag of the incoming character |
| wr_brk | input | 1 | Break tag of the incoming character |
| rd_en | input | 1 | Host data read (pop) strobe |
| lsr_rd | input | 1 | Host status-read strobe |
| irq_en | input | 1 | Line-status interrupt enable |
| imm_mode | input | 1 | Interrupt timing: 0 deferred, 1 immediate |
| rd_data | output | DATA_W | Data byte at the read head |
| rd_pe | output | 1 | Parity-error tag at the read head |
| rd_fe | output | 1 | Framing-error tag at the read head |
| rd_brk | output | 1 | Break tag at the read head |
| empty | output | 1 | Store holds no entry |
| full | output | 1 | Store holds DEPTH entries |
| level | output | $clog2(DEPTH+1) | Number of stored entries |
| err_any | output | 1 | At least one stored entry is tagged |
| overrun | output | 1 | Sticky dropped-write flag |
| lsr_irq | output | 1 | Line-status interrupt |

## Verification
The hardest case to reach is the second immediate-mode interrupt. A tagged character has to sit behind clean ones, be acknowledged by a status read while still buried, and only then be moved to the head by data reads. The stimulus table builds that exact sequence cycle by cycle. The same table walks a deferred-mode arrival into an empty store and a gating interval with the enable low. Directed tests then fill the store to DEPTH, try a dropped write and a simultaneous write-and-read at full, and drain the store to watch the summary flag fall at the right entry.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  parameter int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rxf_entry_t;

  // any tag set on an entry
  function automatic logic entry_bad(rxf_entry_t e);
    return e.pe | e.fe | e.brk;
  endfunction

  // up/down step used by occupancy and error counters
  function automatic int unsigned cnt_step(int unsigned v, logic up, logic dn);
    if (up && !dn) return v + 1;
    if (dn && !up) return v - 1;
    return v;
  endfunction

  // circular pointer advance
  function automatic int unsigned ptr_next(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic       pop,
  input  rxf_entry_t wentry,
  output rxf_entry_t head,
  output logic [LW-1:0] level,
  output logic       empty,
  output logic       full
);
  rxf_entry_t    mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wentry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= AW'(ptr_next(32'(wptr), DEPTH));
      if (pop)  rptr <= AW'(ptr_next(32'(rptr), DEPTH));
      level <= LW'(cnt_step(32'(level), push, pop));
    end
  end

  assign head  = mem[rptr];
  assign empty = (level == '0);
  assign full  = (level == LW'(DEPTH));
endmodule

// File: rtl/rxf_errcnt.sv
module rxf_errcnt
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_bad,
  input  logic pop_bad,
  output logic err_any
);
  logic [LW-1:0] bad_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) bad_cnt <= '0;
    else        bad_cnt <= LW'(cnt_step(32'(bad_cnt), push_bad, pop_bad));
  end

  assign err_any = (bad_cnt != '0);
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr,
  input  logic irq_en,
  output logic pend,
  output logic lsr_irq
);
  always_ff @(posedge clk) begin
    if (!rst_n)       pend <= 1'b0;
    else if (set_evt) pend <= 1'b1;
    else if (clr)     pend <= 1'b0;
  end

  assign lsr_irq = pend & irq_en;
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_pe,
  input  logic              wr_fe,
  input  logic              wr_brk,
  input  logic              rd_en,
  input  logic              lsr_rd,
  input  logic              irq_en,
  input  logic              imm_mode,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pe,
  output logic              rd_fe,
  output logic              rd_brk,
  output logic              empty,
  output logic              full,
  output logic [LW-1:0]     level,
  output logic              err_any,
  output logic              overrun,
  output logic              lsr_irq
);
  rxf_entry_t wentry, head;
  logic push_ok, pop_ok, push_bad, pop_bad;
  logic head_fresh_d, head_fresh_q, head_arrive, imm_evt, set_evt, irq_pend;

  assign wentry   = '{brk: wr_brk, fe: wr_fe, pe: wr_pe, data: wr_data};
  assign pop_ok   = rd_en & ~empty;
  assign push_ok  = wr_en & (~full | pop_ok);
  assign push_bad = push_ok & entry_bad(wentry);
  assign pop_bad  = pop_ok & entry_bad(head);

  // a new entry occupies the head after this edge
  assign head_fresh_d = (pop_ok & ((level > LW'(1)) | push_ok)) | (push_ok & empty);

  always_ff @(posedge clk) begin
    if (!rst_n) head_fresh_q <= 1'b0;
    else        head_fresh_q <= head_fresh_d;
  end

  assign head_arrive = head_fresh_q & ~empty & entry_bad(head);
  assign imm_evt     = imm_mode & push_bad;
  assign set_evt     = head_arrive | imm_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)                overrun <= 1'b0;
    else if (wr_en && !push_ok) overrun <= 1'b1;
    else if (lsr_rd)           overrun <= 1'b0;
  end

  rxf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ok), .pop(pop_ok), .wentry(wentry),
    .head(head), .level(level), .empty(empty), .full(full)
  );

  rxf_errcnt #(.DEPTH(DEPTH)) u_errcnt (
    .clk(clk), .rst_n(rst_n), .push_bad(push_bad), .pop_bad(pop_bad), .err_any(err_any)
  );

  rxf_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr(lsr_rd), .irq_en(irq_en),
    .pend(irq_pend), .lsr_irq(lsr_irq)
  );

  assign rd_data = head.data;
  assign rd_pe   = head.pe;
  assign rd_fe   = head.fe;
  assign rd_brk  = head.brk;
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          lsr_rd,
  input logic          irq_en,
  input logic          imm_mode,
  input logic          bad_in,
  input logic          empty,
  input logic          full,
  input logic [LW-1:0] level,
  input logic          err_any,
  input logic          overrun,
  input logic          lsr_irq,
  input logic          irq_pend,
  input logic          push_ok,
  input logic          set_evt
);
  p_drop_sets_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> overrun);
  p_drop_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !rd_en) |=> (level == LW'(DEPTH)));
  p_bad_push_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && bad_in) |=> err_any);
  p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !lsr_irq);
  p_imm_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_mode && push_ok && bad_in) |=> irq_pend);
  p_status_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !set_evt) |=> !irq_pend);
  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en && !wr_en) |=> empty);
  p_full_swap_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && rd_en) |=> (full && !$rose(overrun)));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .lsr_rd(lsr_rd),
  .irq_en(irq_en), .imm_mode(imm_mode), .bad_in(wr_pe | wr_fe | wr_brk),
  .empty(empty), .full(full), .level(level), .err_any(err_any), .overrun(overrun),
  .lsr_irq(lsr_irq), .irq_pend(irq_pend), .push_ok(push_ok), .set_evt(set_evt)
);

// File: tb/rx_err_fifo_tb.sv
`timescale 1ns/1ps
module rx_err_fifo_tb;
  localparam int DEPTH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, wr_pe = 0, wr_fe = 0, wr_brk = 0, rd_en = 0, lsr_rd = 0, irq_en = 0, imm_mode = 0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic rd_pe, rd_fe, rd_brk, empty, full, err_any, overrun, lsr_irq;
  logic [5:0] level;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  rx_err_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_pe(wr_pe),
    .wr_fe(wr_fe), .wr_brk(wr_brk), .rd_en(rd_en), .lsr_rd(lsr_rd), .irq_en(irq_en),
    .imm_mode(imm_mode), .rd_data(rd_data), .rd_pe(rd_pe), .rd_fe(rd_fe), .rd_brk(rd_brk),
    .empty(empty), .full(full), .level(level), .err_any(err_any), .overrun(overrun),
    .lsr_irq(lsr_irq)
  );

  typedef struct packed {
    logic wr; logic [2:0] tag; logic [7:0] d; logic rd; logic lsr; logic en; logic md;
    logic [5:0] lvl; logic err; logic irq; logic [7:0] hd;
  } vec_t;

  // tag = {brk, fe, pe}; expectations hold after the edge applying the row
  localparam vec_t TBL [18] = '{
    '{1'b1, 3'b000, 8'h11, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1, 1'b0, 1'b0, 8'h11}, // R1
    '{1'b1, 3'b001, 8'h22, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2, 1'b1, 1'b0, 8'h11}, // R4 R7 buried
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 6'd2, 1'b1, 1'b0, 8'h11},
    '{1'b0, 3'b000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b0, 8'h22}, // head moves
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b1, 8'h22}, // R7 fires
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 6'd1, 1'b1, 1'b0, 8'h22}, // R9
    '{1'b0, 3'b000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0, 8'h00}, // R5
    '{1'b1, 3'b100, 8'h33, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b0, 8'h33}, // into empty
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b1, 8'h33}, // R7
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 6'd1, 1'b1, 1'b0, 8'h33}, // R6 gated
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 6'd1, 1'b1, 1'b1, 8'h33}, // R6 kept
    '{1'b0, 3'b000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b0, 6'd0, 1'b0, 1'b0, 8'h00},
    '{1'b1, 3'b000, 8'h44, 1'b0, 1'b0, 1'b1, 1'b1, 6'd1, 1'b0, 1'b0, 8'h44},
    '{1'b1, 3'b010, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1, 6'd2, 1'b1, 1'b1, 8'h44}, // R8
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 6'd2, 1'b1, 1'b0, 8'h44}, // R9
    '{1'b0, 3'b000, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 6'd1, 1'b1, 1'b0, 8'h55},
    '{1'b0, 3'b000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 6'd1, 1'b1, 1'b1, 8'h55}, // R10
    '{1'b0, 3'b000, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 1'b0, 1'b0, 8'h00}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic w, logic [2:0] t, logic [7:0] d, logic r, logic l);
    @(negedge clk);
    wr_en = w; {wr_brk, wr_fe, wr_pe} = t; wr_data = d; rd_en = r; lsr_rd = l;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) step();
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R2 empty", 32'(empty), 1); chk("R2 level", 32'(level), 0);
    chk("R2 err_any", 32'(err_any), 0); chk("R2 overrun", 32'(overrun), 0);
    chk("R2 lsr_irq", 32'(lsr_irq), 0);

    foreach (TBL[i]) begin
      drive(TBL[i].wr, TBL[i].tag, TBL[i].d, TBL[i].rd, TBL[i].lsr);
      irq_en = TBL[i].en; imm_mode = TBL[i].md;
      step();
      chk($sformatf("R1 level row %0d", i), 32'(level), 32'(TBL[i].lvl));
      chk($sformatf("R4 err_any row %0d", i), 32'(err_any), 32'(TBL[i].err));
      chk($sformatf("R7 lsr_irq row %0d", i), 32'(lsr_irq), 32'(TBL[i].irq));
      if (TBL[i].lvl != 0) chk($sformatf("R1 head row %0d", i), 32'(rd_data), 32'(TBL[i].hd));
    end

    // R11: pop while empty, then a normal write
    irq_en = 0; imm_mode = 0;
    drive(0, 3'b000, 8'h00, 1, 0); step();
    chk("R11 still empty", 32'(empty), 1);
    drive(1, 3'b000, 8'h5A, 0, 0); step();
    chk("R11 level after write", 32'(level), 1);
    chk("R11 head after write", 32'(rd_data), 32'h5A);

    // fresh start for the full-store tests
    @(negedge clk); rst_n = 0; wr_en = 0; rd_en = 0; step();
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < DEPTH; i++) begin
      drive(1, (i == 5) ? 3'b001 : 3'b000, 8'(i), 0, 0); step();
    end
    chk("R3 full", 32'(full), 1);
    chk("R4 err_any with one tagged entry", 32'(err_any), 1);
    drive(1, 3'b000, 8'hAA, 0, 0); step();
    chk("R3 level kept", 32'(level), DEPTH);
    chk("R3 overrun set", 32'(overrun), 1);
    chk("R3 head unchanged", 32'(rd_data), 0);
    drive(1, 3'b000, 8'h77, 1, 0); step();
    chk("R12 level", 32'(level), DEPTH);
    chk("R12 head advanced", 32'(rd_data), 1);
    drive(0, 3'b000, 8'h00, 0, 1); step();
    chk("R3 overrun cleared", 32'(overrun), 0);
    for (int k = 0; k < DEPTH; k++) begin
      chk("R1 drain order", 32'(rd_data), (k == DEPTH - 1) ? 32'h77 : 32'(k + 1));
      if (k + 1 == 5) chk("R1 tag at head", 32'(rd_pe), 1);
      chk("R5 err_any while draining", 32'(err_any), (k + 1 <= 5) ? 1 : 0);
      drive(0, 3'b000, 8'h00, 1, 0); step();
    end
    chk("R5 err_any after drain", 32'(err_any), 0);
    chk("R1 empty after drain", 32'(empty), 1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule